// File: doc/BRIEF.md
# Crypto Engine Control Front-End

This block is the register and sequencing layer of a combined cipher and hash accelerator. Software reaches it over a simple memory-mapped word bus. It holds the operation configuration, source and destination addresses, the byte length, and four mode-data words for an IV or counter. It accepts start commands only when the programmed length suits the selected mode. It tracks whether the engine is idle, busy, or parked between fragments of a multi-part input, and it raises a sticky completion interrupt.

The AES and hash datapaths are not part of this block. Their run time is modelled as a fixed latency of `DONE_LAT` cycles after an accepted start. A single length checker and a single three-state sequencer serve both the cipher and hash families. When the "more input follows" flag is set, a finished fragment leaves the engine waiting for further input rather than idle.

Top module: `crypto_fe_top`

## Requirements
- R1: After reset the status word reads 1 (inactive set, all other flags clear), `irq` is low, and the control, fetch, destination and length registers read 0.
- R2: In cipher mode (control bit 0 = 0), a start is accepted when the length (address 3) is a multiple of 16. When the more-input bit (control bit 7) is clear and the mode field (control bits 2:1) is 2 (CTR) or 3 (CBC), any length is also accepted. Mode values 0 and 1 (ECB) always need a multiple of 16.
- R3: In hash mode (control bit 0 = 1), a start is accepted for any length when the more-input bit is clear, and only for a multiple of 8 when it is set.
- R4: A start is a write of 1 in bit 0 to address 8. When accepted, the status reads busy (bits 1:0 both 0) for exactly `DONE_LAT` cycles. If more-input was clear when the start was accepted, the engine then returns to inactive (status bit 0).
- R5: If more-input was set when the start was accepted, completion leaves the engine waiting for input: status bit 1 set, bit 0 clear. A valid start is accepted from this state.
- R6: A start issued while busy, or with a length that breaks R2/R3, is ignored: the engine state does not change. Such a start sets the sticky length-error flag (status bit 3). The next accepted start clears the flag.
- R7: Completion sets the interrupt flag (status bit 2, mirrored on `irq`) only when interrupt-enable (control bit 8) is 1. The flag stays set until a write of 1 in bit 0 to address 10.
- R8: A write to address 12 zeroes the four mode-data words (read at addresses 4 to 7) and points loading at word 3. Each write to address 11 stores its data byte-reversed into the pointed word and moves the pointer one word down. Writes beyond word 0 are dropped.
- R9: Address 13 reads the full hash output-length code in bits 5:0 and the key size in bits in bits 16:8. The length code is selected by the family (control bit 1) and the algorithm field (control bits 4:3): 15, 19, 27, 31 for family 0 and 47, 63, 27, 31 for family 1. The key size is selected by control bits 6:5: 0 gives 128, 1 gives 192, 2 gives 256, 3 gives 0.
- R10: The control register (16 bits, address 0), fetch address (address 1), destination address (address 2) and length (16 bits, address 3) read back what was written. Reads return data one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data valid next cycle |
| bus_addr | input | ADR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench builds the block with `DONE_LAT` = 5 and the default 16-bit length and four mode-data words. This short latency lets every start be followed to completion within a few reads. The bench sweeps both families, all four mode-field values, both more-input settings and every length from 0 to 40, which covers each side of the 8- and 16-byte boundaries. From each accepted start it also counts the exact busy window and the resulting idle or waiting state. All 32 family, algorithm and key-size combinations of the information register are swept, along with mode-data loading past the last word.

// File: rtl/crypto_fe_pkg.sv
package crypto_fe_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_WAIT} eng_state_t;

  localparam int unsigned ADR_CTRL  = 0;
  localparam int unsigned ADR_FETCH = 1;
  localparam int unsigned ADR_DEST  = 2;
  localparam int unsigned ADR_LEN   = 3;
  localparam int unsigned ADR_MD0   = 4;
  localparam int unsigned ADR_START = 8;
  localparam int unsigned ADR_STAT  = 9;
  localparam int unsigned ADR_CLR   = 10;
  localparam int unsigned ADR_PUSH  = 11;
  localparam int unsigned ADR_MDCLR = 12;
  localparam int unsigned ADR_INFO  = 13;

  function automatic logic [5:0] full_outlen(input logic fam, input logic [1:0] alg);
    logic [5:0] r;
    case (alg)
      2'd0:    r = fam ? 6'd47 : 6'd15;
      2'd1:    r = fam ? 6'd63 : 6'd19;
      2'd2:    r = 6'd27;
      default: r = 6'd31;
    endcase
    return r;
  endfunction

  function automatic logic [8:0] key_bits(input logic [1:0] ks);
    logic [8:0] r;
    case (ks)
      2'd0:    r = 9'd128;
      2'd1:    r = 9'd192;
      2'd2:    r = 9'd256;
      default: r = 9'd0;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction
endpackage

// File: rtl/crypto_fe_lenchk.sv
module crypto_fe_lenchk (
  input  logic       hash_sel,
  input  logic [1:0] mode,
  input  logic       more_in,
  input  logic [3:0] len_lo,
  output logic       len_ok
);
  logic mult8, mult16, stream_mode;

  always_comb begin
    mult8       = (len_lo[2:0] == 3'd0);
    mult16      = (len_lo == 4'd0);
    stream_mode = mode[1];
    if (hash_sel) len_ok = !more_in || mult8;
    else          len_ok = mult16 || (!more_in && stream_mode);
  end
endmodule

// File: rtl/crypto_fe_seq.sv
module crypto_fe_seq #(
  parameter int unsigned DONE_LAT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_wr,
  input  logic len_ok,
  input  logic more_in,
  input  logic irq_en,
  input  logic irq_clr,
  output logic inactive,
  output logic wait_in,
  output logic irq_st,
  output logic len_err
);
  import crypto_fe_pkg::*;
  localparam int unsigned CNT_W = $clog2(DONE_LAT + 1);

  eng_state_t st;
  logic [CNT_W-1:0] cnt;
  logic more_q, accept, done;

  assign accept   = start_wr && (st != ST_BUSY) && len_ok;
  assign done     = (st == ST_BUSY) && (cnt == '0);
  assign inactive = (st == ST_IDLE);
  assign wait_in  = (st == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      more_q  <= 1'b0;
      irq_st  <= 1'b0;
      len_err <= 1'b0;
    end else begin
      if (accept) len_err <= 1'b0;
      else if (start_wr) len_err <= 1'b1;
      if (accept) begin
        st     <= ST_BUSY;
        cnt    <= CNT_W'(DONE_LAT - 1);
        more_q <= more_in;
      end else if (done) begin
        st <= more_q ? ST_WAIT : ST_IDLE;
      end else if (st == ST_BUSY) begin
        cnt <= cnt - 1'b1;
      end
      if (done && irq_en) irq_st <= 1'b1;
      else if (irq_clr)   irq_st <= 1'b0;
    end
  end

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BUSY && cnt != '0) |=> st == ST_BUSY);
  a_r5_wait_after_more: assert property (@(posedge clk) disable iff (rst)
    (done && more_q) |=> wait_in && !inactive);
  a_r6_busy_reject: assert property (@(posedge clk) disable iff (rst)
    (start_wr && st == ST_BUSY) |=> len_err);
  a_r6_accept_clears: assert property (@(posedge clk) disable iff (rst)
    accept |=> !len_err && st == ST_BUSY);
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_st && !irq_clr) |=> irq_st);
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_st) |-> $past(irq_en) && $past(st == ST_BUSY));
endmodule

// File: rtl/crypto_fe_mdata.sv
module crypto_fe_mdata #(
  parameter int unsigned NWORDS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   push,
  input  logic [31:0]            wdata,
  output logic [NWORDS-1:0][31:0] words
);
  import crypto_fe_pkg::*;
  localparam int unsigned PTR_W = $clog2(NWORDS);

  logic [PTR_W:0]   left;
  logic [PTR_W-1:0] idx;
  assign idx = PTR_W'(left - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      words <= '0;
      left  <= (PTR_W+1)'(NWORDS);
    end else if (push && left != '0) begin
      words[idx] <= bswap32(wdata);
      left       <= left - 1'b1;
    end
  end

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> words == '0);
  a_r8_full_drop: assert property (@(posedge clk) disable iff (rst)
    (left == '0 && push && !clr) |=> $stable(words));
endmodule

// File: rtl/crypto_fe_top.sv
module crypto_fe_top #(
  parameter int unsigned ADR_W    = 4,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned NWORDS   = 4,
  parameter int unsigned DONE_LAT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [ADR_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq
);
  import crypto_fe_pkg::*;
  localparam int unsigned CTRL_W = 16;
  localparam int unsigned PTR_W  = $clog2(NWORDS);

  logic [CTRL_W-1:0] ctrl_q;
  logic [31:0]       fetch_q, dest_q;
  logic [LEN_W-1:0]  len_q;
  logic [NWORDS-1:0][31:0] md_words;
  logic len_ok, inactive, wait_in, irq_st, len_err;
  logic start_wr, clr_wr, push_wr, mdclr_wr;
  logic [PTR_W-1:0] md_idx;

  assign start_wr = bus_wr && bus_addr == ADR_W'(ADR_START) && bus_wdata[0];
  assign clr_wr   = bus_wr && bus_addr == ADR_W'(ADR_CLR)   && bus_wdata[0];
  assign push_wr  = bus_wr && bus_addr == ADR_W'(ADR_PUSH);
  assign mdclr_wr = bus_wr && bus_addr == ADR_W'(ADR_MDCLR);
  assign md_idx   = PTR_W'(bus_addr - ADR_W'(ADR_MD0));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      fetch_q <= '0;
      dest_q  <= '0;
      len_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADR_W'(ADR_CTRL):  ctrl_q  <= bus_wdata[CTRL_W-1:0];
        ADR_W'(ADR_FETCH): fetch_q <= bus_wdata;
        ADR_W'(ADR_DEST):  dest_q  <= bus_wdata;
        ADR_W'(ADR_LEN):   len_q   <= bus_wdata[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  crypto_fe_lenchk u_lenchk (
    .hash_sel(ctrl_q[0]), .mode(ctrl_q[2:1]), .more_in(ctrl_q[7]),
    .len_lo(len_q[3:0]), .len_ok(len_ok)
  );

  crypto_fe_seq #(.DONE_LAT(DONE_LAT)) u_seq (
    .clk(clk), .rst(rst), .start_wr(start_wr), .len_ok(len_ok),
    .more_in(ctrl_q[7]), .irq_en(ctrl_q[8]), .irq_clr(clr_wr),
    .inactive(inactive), .wait_in(wait_in), .irq_st(irq_st), .len_err(len_err)
  );

  crypto_fe_mdata #(.NWORDS(NWORDS)) u_mdata (
    .clk(clk), .rst(rst), .clr(mdclr_wr), .push(push_wr),
    .wdata(bus_wdata), .words(md_words)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        ADR_W'(ADR_CTRL):  bus_rdata <= 32'(ctrl_q);
        ADR_W'(ADR_FETCH): bus_rdata <= fetch_q;
        ADR_W'(ADR_DEST):  bus_rdata <= dest_q;
        ADR_W'(ADR_LEN):   bus_rdata <= 32'(len_q);
        ADR_W'(ADR_STAT):  bus_rdata <= {28'd0, len_err, irq_st, wait_in, inactive};
        ADR_W'(ADR_INFO):  bus_rdata <= {15'd0, key_bits(ctrl_q[6:5]), 2'd0,
                                         full_outlen(ctrl_q[1], ctrl_q[4:3])};
        default:
          if (bus_addr >= ADR_W'(ADR_MD0) && bus_addr < ADR_W'(ADR_MD0 + NWORDS))
            bus_rdata <= md_words[md_idx];
      endcase
    end
  end

  assign irq = irq_st;

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> inactive && !irq);
  a_r4_single_state: assert property (@(posedge clk) disable iff (rst)
    !(inactive && wait_in));
endmodule

// File: tb/test_crypto_fe_top.sv
module test_crypto_fe_top;
  localparam int LAT = 5;
  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  crypto_fe_top #(.DONE_LAT(LAT)) i_crypto_fe_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1; bus_addr = 4'(a);
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  function automatic logic [31:0] bsw(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  logic [31:0] d;
  bit prev_wait;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(9, d); chk(d == 32'h1, "R1 status", d, 32'h1);
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    for (int a = 0; a < 4; a++) begin rd(a, d); chk(d == 0, "R1 reg", d, 0); end
    // R10 read-back
    wr(0, 32'hFFFF_A5C3); rd(0, d); chk(d == 32'h0000_A5C3, "R10 ctrl", d, 32'h0000_A5C3);
    wr(1, 32'hDEAD_BEEF); rd(1, d); chk(d == 32'hDEAD_BEEF, "R10 fetch", d, 32'hDEAD_BEEF);
    wr(2, 32'h1234_5678); rd(2, d); chk(d == 32'h1234_5678, "R10 dest", d, 32'h1234_5678);
    wr(3, 32'h0007_0ABC); rd(3, d); chk(d == 32'h0000_0ABC, "R10 len", d, 32'h0000_0ABC);

    // R2 R3 R4 R5 R6 R7 sweep
    prev_wait = 0;
    for (int h = 0; h < 2; h++)
      for (int m = 0; m < 4; m++)
        for (int mo = 0; mo < 2; mo++)
          for (int len = 0; len <= 40; len++) begin
            bit ok;
            int busy_n;
            if (h == 1) ok = (mo == 0) || (len % 8 == 0);
            else ok = (len % 16 == 0) || (mo == 0 && m >= 2);
            wr(0, 32'(h) | (32'(m) << 1) | (32'(mo) << 7) | (32'd1 << 8));
            wr(3, 32'(len));
            wr(8, 1);
            if (!ok) begin
              rd(9, d);
              chk(d == {28'd0, 1'b1, 1'b0, prev_wait, !prev_wait},
                  h ? "R3 R6 reject" : "R2 R6 reject", d,
                  {28'd0, 1'b1, 1'b0, prev_wait, !prev_wait});
            end else begin
              busy_n = 0;
              for (int k = 0; k < 50; k++) begin
                rd(9, d);
                if (k == 0) chk(d[3] == 0, "R6 err cleared", d, 32'h0);
                if (d[1:0] != 0) break;
                busy_n++;
              end
              chk(busy_n == LAT, h ? "R3 R4 busy window" : "R2 R4 busy window",
                  32'(busy_n), 32'(LAT));
              chk(d[1:0] == (mo ? 2'b10 : 2'b01), mo ? "R5 wait state" : "R4 idle state",
                  d, mo ? 32'h2 : 32'h1);
              chk(d[2] == 1 && irq == 1, "R7 irq set", {d[2], irq}, 2'b11);
              wr(10, 1);
              prev_wait = (mo == 1);
            end
          end

    // R7 clear, gating
    rd(9, d); chk(d[2] == 0 && irq == 0, "R7 cleared", d[2], 0);
    wr(0, 32'h1); wr(3, 8); wr(8, 1);
    repeat (LAT + 2) @(negedge clk);
    rd(9, d); chk(d == 32'h1, "R7 gated off", d, 32'h1);
    chk(irq == 0, "R7 irq gated", 32'(irq), 0);

    // R6 start while busy
    wr(0, 32'h101); wr(3, 16); wr(8, 1); wr(8, 1);
    rd(9, d); chk(d == 32'h8, "R6 busy reject", d, 32'h8);
    repeat (LAT + 2) @(negedge clk);
    rd(9, d); chk(d == 32'hD, "R6 op unaffected", d, 32'hD);
    wr(10, 1);
    wr(10, 0); rd(9, d); chk(d == 32'h9, "R7 clear needs bit0", d, 32'h9);

    // R8 mode data
    wr(12, 0);
    for (int w = 0; w < 4; w++) begin rd(4 + w, d); chk(d == 0, "R8 zeroed", d, 0); end
    for (int p = 0; p < 5; p++) wr(11, 32'h1020_3040 + 32'(p) * 32'h0101_0101);
    for (int w = 0; w < 4; w++) begin
      logic [31:0] e;
      e = bsw(32'h1020_3040 + 32'(3 - w) * 32'h0101_0101);
      rd(4 + w, d); chk(d == e, "R8 byte-reversed load", d, e);
    end
    wr(12, 0); wr(11, 32'hAABB_CCDD);
    rd(7, d); chk(d == 32'hDDCC_BBAA, "R8 reload top", d, 32'hDDCC_BBAA);
    rd(6, d); chk(d == 0, "R8 reload rest", d, 0);

    // R9 info
    for (int f = 0; f < 2; f++)
      for (int a = 0; a < 4; a++)
        for (int ks = 0; ks < 4; ks++) begin
          int ol, kb;
          case (a)
            0: ol = f ? 47 : 15;
            1: ol = f ? 63 : 19;
            2: ol = 27;
            default: ol = 31;
          endcase
          kb = (ks == 3) ? 0 : 128 + 64 * ks;
          wr(0, 32'h1 | (32'(f) << 1) | (32'(a) << 3) | (32'(ks) << 5));
          rd(13, d);
          chk(d == (32'(kb) << 8 | 32'(ol)), "R9 info", d, 32'(kb) << 8 | 32'(ol));
        end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule